// File: doc/BRIEF.md
# Two-Lane Fast FIR Filter

This block filters a sample stream that arrives two samples per clock. Each accepted beat carries an even-indexed sample on one lane and the odd-indexed sample that follows it on the other lane. Each result beat carries the matching pair of output samples. Read as one interleaved stream, the outputs are exactly what a serial N-tap FIR filter with the same coefficients produces when fed the interleaved input. The coefficients are fixed when the block is built. N must be even and at least four.

The work is split into three half-length direct-form sub-filters instead of four:

- One sub-filter holds the even-indexed taps and runs on the even lane.
- One sub-filter holds the odd-indexed taps and runs on the odd lane.
- A middle sub-filter holds merged taps and runs on a combined lane. The merged taps are the even tap plus the odd tap, or the even tap minus the odd tap. The combined lane is the sum or the difference of the two input lanes. Both the merged taps and the combined lane are one bit wider than their operands.

The outputs of the first two sub-filters feed both output equations. A registered post-combiner forms the final pair. A build parameter picks the sum form or the difference form of the middle branch. Both forms give identical results.

A beat is accepted only when `in_valid` is high. The result pair appears one clock later with `out_valid` high. Between accepted beats, the sub-filter histories and the outputs hold their values.

Top module: `duo_fir`

## Requirements
- R1: On each result beat, `y_even` equals the serial N-tap response at the even stream index: the sum over k of h[k]·x(2n−k). Here x(2n) is `x_even` and x(2n+1) is `x_odd` of beat n. Samples from before reset count as zero.
- R2: With the sum form (`FORM` = `FORM_SUM`), `y_odd` equals the serial response at stream index 2n+1.
- R3: With the difference form (`FORM` = `FORM_DIFF`), both lanes give the same serial response as in R1 and R2.
- R4: `out_valid` is high in the clock cycle after the clock edge at which `in_valid` was sampled high, and low in every other cycle.
- R5: A clock edge with `in_valid` low changes neither output lane, and it does not advance the filter history. Results after a gap equal those of an unbroken stream.
- R6: While `rst_n` is low, `out_valid`, `y_even` and `y_odd` are zero. Reset also clears the history, so the first results after reset count earlier samples as zero.
- R7: Results are exact in two's complement for any inputs in range, including runs of the most negative input value on both lanes.
- R8: A unit impulse at stream index j produces h[0], h[1], … h[N−1] on the interleaved output starting at index j. This holds whether the impulse is on the even lane or the odd lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Beat strobe: both input lanes carry a new pair |
| x_even | input | DW | Sample x(2n), signed |
| x_odd | input | DW | Sample x(2n+1), signed |
| out_valid | output | 1 | Result pair present this cycle |
| y_even | output | DW+CW+log2(N) | Result y(2n), signed |
| y_odd | output | DW+CW+log2(N) | Result y(2n+1), signed |

## Verification
The zero-run property assumes one thing about the inputs: a filter whose last N/2+1 accepted beats were all zero must give zero on both lanes. It therefore counts only beats accepted under `in_valid`. The stimulus provides such runs after each impulse so that this premise is actually exercised.

The latency and hold properties assume that `in_valid` is a clean level sampled at the rising edge. The bench changes it only on falling edges.

The output width assumes input samples stay within DW signed bits. The full-scale runs use exactly the most negative and most positive codes and go no further.

// File: rtl/duo_fir_pkg.sv
package duo_fir_pkg;

    typedef enum logic {
        FORM_SUM  = 1'b0,
        FORM_DIFF = 1'b1
    } mid_form_e;

endpackage

// File: rtl/duo_fir_phase.sv
// Half-length direct-form sub-filter. The history advances only on adv.
module duo_fir_phase #(
    parameter int                      TAPS = 4,
    parameter int                      IW   = 12,
    parameter int                      CW   = 8,
    parameter int                      SW   = 25,
    parameter logic [TAPS*CW-1:0]      COEF = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 adv,
    input  logic signed [IW-1:0] din,
    output logic signed [SW-1:0] acc
);
    localparam int HIST = TAPS - 1;

    logic signed [IW-1:0] hist [HIST];
    logic signed [IW-1:0] taps [TAPS];

    assign taps[0] = din;

    generate
        for (genvar g = 1; g < TAPS; g++) begin : g_tap
            assign taps[g] = hist[g-1];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < HIST; i++) hist[i] <= '0;
        end else if (adv) begin
            hist[0] <= din;
            for (int i = 1; i < HIST; i++) hist[i] <= hist[i-1];
        end
    end

    logic signed [SW-1:0] s_sum;
    logic signed [SW-1:0] c_ext;
    logic signed [SW-1:0] d_ext;

    always_comb begin
        s_sum = '0;
        c_ext = '0;
        d_ext = '0;
        for (int k = 0; k < TAPS; k++) begin
            c_ext = SW'($signed(COEF[k*CW +: CW]));
            d_ext = SW'(taps[k]);
            s_sum = s_sum + c_ext * d_ext;
        end
    end

    assign acc = s_sum;

endmodule

// File: rtl/duo_fir_post.sv
// Registered post-combiner: forms the even and odd result pair.
module duo_fir_post
    import duo_fir_pkg::*;
#(
    parameter int        SW   = 25,
    parameter int        OW   = 23,
    parameter mid_form_e FORM = FORM_SUM
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 adv,
    input  logic signed [SW-1:0] ev_acc,
    input  logic signed [SW-1:0] od_acc,
    input  logic signed [SW-1:0] md_acc,
    output logic                 vld,
    output logic signed [OW-1:0] y0,
    output logic signed [OW-1:0] y1
);
    logic signed [SW-1:0] od_prev;
    logic signed [SW-1:0] y0_next;
    logic signed [SW-1:0] y1_next;

    assign y0_next = ev_acc + od_prev;

    generate
        if (FORM == FORM_SUM) begin : g_sum
            assign y1_next = md_acc - ev_acc - od_acc;
        end else begin : g_diff
            assign y1_next = ev_acc + od_acc - md_acc;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            od_prev <= '0;
            y0      <= '0;
            y1      <= '0;
            vld     <= 1'b0;
        end else begin
            vld <= adv;
            if (adv) begin
                od_prev <= od_acc;
                y0      <= OW'(y0_next);
                y1      <= OW'(y1_next);
            end
        end
    end

endmodule

// File: rtl/duo_fir.sv
module duo_fir
    import duo_fir_pkg::*;
#(
    parameter int                  NTAPS = 8,
    parameter int                  DW    = 12,
    parameter int                  CW    = 8,
    parameter mid_form_e           FORM  = FORM_SUM,
    parameter logic [NTAPS*CW-1:0] COEFS = {8'hFD, 8'h09, 8'hEC, 8'h7F,
                                            8'h5A, 8'h1B, 8'hF4, 8'h80},
    localparam int                 OW    = DW + CW + $clog2(NTAPS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [DW-1:0] x_even,
    input  logic signed [DW-1:0] x_odd,
    output logic                 out_valid,
    output logic signed [OW-1:0] y_even,
    output logic signed [OW-1:0] y_odd
);
    localparam int HALF = NTAPS / 2;
    localparam int MW   = CW + 1;
    localparam int XW   = DW + 1;
    localparam int SW   = OW + 2;

    function automatic logic [HALF*CW-1:0] phase_pick(input int ph);
        logic [HALF*CW-1:0] r;
        r = '0;
        for (int m = 0; m < HALF; m++)
            r[m*CW +: CW] = COEFS[(2*m+ph)*CW +: CW];
        return r;
    endfunction

    function automatic logic [HALF*MW-1:0] mid_pick();
        logic [HALF*MW-1:0] r;
        logic signed [MW-1:0] c0;
        logic signed [MW-1:0] c1;
        r = '0;
        for (int m = 0; m < HALF; m++) begin
            c0 = MW'($signed(COEFS[(2*m)*CW +: CW]));
            c1 = MW'($signed(COEFS[(2*m+1)*CW +: CW]));
            r[m*MW +: MW] = (FORM == FORM_SUM) ? (c0 + c1) : (c0 - c1);
        end
        return r;
    endfunction

    localparam logic [HALF*CW-1:0] EV_COEF = phase_pick(0);
    localparam logic [HALF*CW-1:0] OD_COEF = phase_pick(1);
    localparam logic [HALF*MW-1:0] MD_COEF = mid_pick();

    logic signed [XW-1:0] x_mid;
    logic signed [SW-1:0] ev_acc;
    logic signed [SW-1:0] od_acc;
    logic signed [SW-1:0] md_acc;

    generate
        if (FORM == FORM_SUM) begin : g_pre_sum
            assign x_mid = XW'(x_even) + XW'(x_odd);
        end else begin : g_pre_diff
            assign x_mid = XW'(x_even) - XW'(x_odd);
        end
    endgenerate

    duo_fir_phase #(.TAPS(HALF), .IW(DW), .CW(CW), .SW(SW), .COEF(EV_COEF)) u_even (
        .clk(clk), .rst_n(rst_n), .adv(in_valid), .din(x_even), .acc(ev_acc)
    );

    duo_fir_phase #(.TAPS(HALF), .IW(DW), .CW(CW), .SW(SW), .COEF(OD_COEF)) u_odd (
        .clk(clk), .rst_n(rst_n), .adv(in_valid), .din(x_odd), .acc(od_acc)
    );

    duo_fir_phase #(.TAPS(HALF), .IW(XW), .CW(MW), .SW(SW), .COEF(MD_COEF)) u_mid (
        .clk(clk), .rst_n(rst_n), .adv(in_valid), .din(x_mid), .acc(md_acc)
    );

    duo_fir_post #(.SW(SW), .OW(OW), .FORM(FORM)) u_post (
        .clk(clk), .rst_n(rst_n), .adv(in_valid),
        .ev_acc(ev_acc), .od_acc(od_acc), .md_acc(md_acc),
        .vld(out_valid), .y0(y_even), .y1(y_odd)
    );

endmodule

// File: rtl/duo_fir_chk.sv
module duo_fir_chk #(
    parameter int DW   = 12,
    parameter int OW   = 23,
    parameter int HALF = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic signed [DW-1:0] x_even,
    input logic signed [DW-1:0] x_odd,
    input logic                 out_valid,
    input logic signed [OW-1:0] y_even,
    input logic signed [OW-1:0] y_odd
);
    localparam int ZW = $clog2(HALF + 2) + 1;

    logic [ZW-1:0] zero_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) zero_run <= '0;
        else if (in_valid) begin
            if (x_even == '0 && x_odd == '0) begin
                if (zero_run < ZW'(HALF)) zero_run <= zero_run + 1'b1;
            end else zero_run <= '0;
        end
    end

    // R4: one-cycle valid latency
    a_r4_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r4_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R5: idle edges leave the outputs alone
    a_r5_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(y_even) && $stable(y_odd)));

    // R6: first edge after reset shows nothing valid
    a_r6_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!out_valid && y_even == '0 && y_odd == '0));

    // R1/R2: a long enough run of zero beats flushes every branch
    a_r1_zero_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && x_even == '0 && x_odd == '0 && zero_run >= ZW'(HALF))
        |=> (y_even == '0 && y_odd == '0));

endmodule

bind duo_fir duo_fir_chk #(.DW(DW), .OW(OW), .HALF(HALF)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .x_even(x_even), .x_odd(x_odd),
    .out_valid(out_valid), .y_even(y_even), .y_odd(y_odd)
);

// File: tb/duo_fir_bench.sv
`timescale 1ns/1ps
module duo_fir_bench;
    import duo_fir_pkg::*;

    localparam int NT = 8;
    localparam int DW = 12;
    localparam int CW = 8;
    localparam int OW = DW + CW + $clog2(NT);
    localparam int H [NT] = '{-128, -12, 27, 90, 127, -20, 9, -3};

    function automatic logic [NT*CW-1:0] pack_h();
        logic [NT*CW-1:0] r;
        for (int k = 0; k < NT; k++) r[k*CW +: CW] = CW'(H[k]);
        return r;
    endfunction
    localparam logic [NT*CW-1:0] HP = pack_h();

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [DW-1:0] x_even = '0;
    logic signed [DW-1:0] x_odd = '0;
    logic out_valid, out_valid_d;
    logic signed [OW-1:0] y_even, y_odd, y_even_d, y_odd_d;

    always #2.5 clk = ~clk;

    duo_fir #(.NTAPS(NT), .DW(DW), .CW(CW), .FORM(FORM_SUM), .COEFS(HP)) u_duo_fir (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .x_even(x_even), .x_odd(x_odd),
        .out_valid(out_valid), .y_even(y_even), .y_odd(y_odd));

    duo_fir #(.NTAPS(NT), .DW(DW), .CW(CW), .FORM(FORM_DIFF), .COEFS(HP)) u_duo_fir_diff (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .x_even(x_even), .x_odd(x_odd),
        .out_valid(out_valid_d), .y_even(y_even_d), .y_odd(y_odd_d));

    int checks = 0;
    int errors = 0;
    int ref_hist [NT];
    int exp_q [$];
    logic v_seen = 1'b0;
    int last_e = 0, last_o = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ref_step(input int x);
        int s = 0;
        for (int k = NT - 1; k > 0; k--) ref_hist[k] = ref_hist[k-1];
        ref_hist[0] = x;
        for (int k = 0; k < NT; k++) s += H[k] * ref_hist[k];
        return s;
    endfunction

    // driver: one accepted beat, expected pair pushed to the scoreboard
    task automatic send(input int a, input int b);
        @(negedge clk);
        in_valid = 1'b1;
        x_even = DW'(a);
        x_odd = DW'(b);
        exp_q.push_back(ref_step(a));
        exp_q.push_back(ref_step(b));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // bench model of R4: which cycles must carry a result
    always @(posedge clk or negedge rst_n)
        if (!rst_n) v_seen <= 1'b0;
        else v_seen <= in_valid;

    // monitor
    always @(negedge clk) begin
        if (rst_n) begin
            chk(out_valid == v_seen, "R4 valid sum", int'(out_valid), int'(v_seen));
            chk(out_valid_d == v_seen, "R4 valid diff", int'(out_valid_d), int'(v_seen));
            if (out_valid) begin
                int ee, eo;
                if (exp_q.size() < 2) begin
                    chk(1'b0, "R1 scoreboard empty", exp_q.size(), 2);
                end else begin
                    ee = exp_q.pop_front();
                    eo = exp_q.pop_front();
                    chk(int'(y_even) == ee, "R1 even lane", int'(y_even), ee);
                    chk(int'(y_odd) == eo, "R2 odd lane sum form", int'(y_odd), eo);
                    chk(int'(y_even_d) == ee, "R3 even lane diff form", int'(y_even_d), ee);
                    chk(int'(y_odd_d) == eo, "R3 odd lane diff form", int'(y_odd_d), eo);
                    last_e = ee;
                    last_o = eo;
                end
            end else begin
                chk(int'(y_even) == last_e && int'(y_odd) == last_o, "R5 hold while idle",
                    int'(y_even), last_e);
                chk(int'(y_even_d) == last_e && int'(y_odd_d) == last_o, "R5 hold diff",
                    int'(y_odd_d), last_o);
            end
        end
    end

    task automatic reset_and_check();
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        for (int k = 0; k < NT; k++) ref_hist[k] = 0;
        last_e = 0;
        last_o = 0;
        @(negedge clk);
        chk(!out_valid && !out_valid_d, "R6 valid low in reset", int'(out_valid), 0);
        chk(y_even == '0 && y_odd == '0, "R6 outputs zero in reset", int'(y_even), 0);
        chk(y_even_d == '0 && y_odd_d == '0, "R6 diff outputs zero", int'(y_odd_d), 0);
        rst_n = 1'b1;
    endtask

    initial begin
        for (int k = 0; k < NT; k++) ref_hist[k] = 0;
        #1;
        chk(!out_valid, "R6 valid low at start", int'(out_valid), 0);
        chk(y_even == '0 && y_odd == '0, "R6 outputs zero at start", int'(y_even), 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R8: impulse on the even lane, then on the odd lane
        send(1, 0);
        for (int i = 0; i < NT; i++) send(0, 0);
        send(0, 1);
        for (int i = 0; i < NT; i++) send(0, 0);
        idle(3);

        // R5: gaps inside a stream
        for (int i = 0; i < 20; i++) begin
            send(i * 37 - 300, 500 - i * 53);
            if (i % 3 == 0) idle(1 + i % 4);
        end

        // R1 R2 R3: random patterns
        for (int i = 0; i < 300; i++) begin
            send(int'($urandom_range(4095)) - 2048, int'($urandom_range(4095)) - 2048);
            if ($urandom_range(7) == 0) idle(1);
        end

        // R7: full scale
        for (int i = 0; i < NT; i++) send(-2048, -2048);
        for (int i = 0; i < NT; i++) send(2047, -2048);
        for (int i = 0; i < NT; i++) send(-2048, 2047);
        for (int i = 0; i < NT + 2; i++) send(0, 0);
        idle(3);

        // R6: reset mid-run clears the history
        send(1000, -1000);
        send(700, 33);
        idle(2);
        reset_and_check();
        send(0, 1);
        for (int i = 0; i < NT; i++) send(0, 0);
        idle(4);

        chk(exp_q.size() == 0, "R1 scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R4 actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule